// File: doc/BRIEF.md
# Word-to-Byte Output Bus Matcher

This block sits on the read side of a FIFO whose storage is always written in 18-bit words. It presents the word at the head of the FIFO on an output register either whole, 18 bits wide, or as two 9-bit halves on consecutive reads. Which half leaves first is fixed by an endian strap. An output-width strap picks between word and byte output. Both straps are sampled only while the synchronous master reset is held low.

The block keeps a half-select bit that tracks which half of the head word is due next. It raises a word-pop strobe in the same cycle as the read that consumes the last part of a word. Storage and flag logic outside the block use that strobe to advance their read pointer. Flag accounting therefore stays on whole-word boundaries, and the 18-bit word is the wider of the two buses. A read request is taken only when the head word is marked valid.

Top module: `bm_word_to_byte`

## Requirements
- R1: While `rst_n` is low, at every rising clock edge `q_out` is cleared to 0 and `next_half` is cleared to 0.
- R2: `strap_endian_le` and `strap_byte_out` are sampled only at clock edges where `rst_n` is low. Changes to them while `rst_n` is high have no effect on `q_out`, `next_half` or `word_pop`.
- R3: In word mode (`strap_byte_out` latched 0), a read taken with `rd_en`=1 and `head_valid`=1 loads `head_word` into `q_out` at the next edge. `word_pop` is 1 in that same cycle, and `next_half` stays 0.
- R4: In byte mode with big-endian order (`strap_endian_le` latched 0), the first read of a word loads bits 17:9 into `q_out[8:0]`. The second read loads bits 8:0.
- R5: In byte mode with little-endian order (`strap_endian_le` latched 1), the first read of a word loads bits 8:0 into `q_out[8:0]`. The second read loads bits 17:9.
- R6: In byte mode, `word_pop` is 1 only for a taken read while `next_half`=1, which is the second half. Each taken read toggles `next_half`.
- R7: When `rd_en` is 0, `q_out` and `next_half` hold their values and `word_pop` is 0.
- R8: When `head_valid` is 0, `rd_en` is ignored: `q_out` and `next_half` hold and `word_pop` is 0.
- R9: In byte mode, `q_out[17:9]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous master reset, active low; straps sampled while low |
| strap_endian_le | input | 1 | Endian strap: 0 big-endian (upper half first), 1 little-endian |
| strap_byte_out | input | 1 | Output width strap: 0 = 18-bit output, 1 = 9-bit output |
| head_word | input | 18 | Word at the FIFO head |
| head_valid | input | 1 | FIFO not empty; head_word is valid |
| rd_en | input | 1 | Read request, active high |
| q_out | output | 18 | Output register; byte mode uses bits 8:0 |
| next_half | output | 1 | Half due next in byte mode: 0 first, 1 second |
| word_pop | output | 1 | Head word fully consumed this cycle |

## Verification
Random read and valid patterns run in each of the four strap combinations against a model that sees the configuration only at reset. This separates the two half orders and word mode from each other. Random strap toggling during operation shows whether a strap leaks past reset. Directed sequences check the corners: reads against an empty FIFO, idle cycles between the two halves of one word, and back-to-back reads across word boundaries. Together they confirm that the half bit neither advances nor pops when it should not.

// File: rtl/bm_pkg.sv
// Package: shared widths and the latched strap configuration type.
// Assumes a word is made of exactly two equal halves.
package bm_pkg;
    localparam int WORD_W = 18;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic little_end;   // 1: lower half leaves first
        logic byte_out;     // 1: half-width output
    } bm_cfg_t;
endpackage

// File: rtl/bm_strap_latch.sv
// Module: captures the configuration straps while master reset is low and
// holds them for the rest of operation. Assumes straps are stable around
// the reset edges.
module bm_strap_latch
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    endian_in,
    input  logic    width_in,
    output bm_cfg_t cfg
);
    // Sample straps only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.little_end <= endian_in;
            cfg.byte_out   <= width_in;
        end
    end
endmodule

// File: rtl/bm_half_track.sv
// Module: tracks which half of the head word is due next and flags the
// read that finishes a word. Assumes 'take' is already qualified by valid.
module bm_half_track
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bm_cfg_t cfg,
    input  logic    take,
    output logic    half,
    output logic    word_done
);
    // A word ends on every take in word mode, on the second half otherwise.
    always_comb word_done = take && (!cfg.byte_out || half);

    // Toggle the half bit on each taken byte-mode read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half <= 1'b0;
        else if (take && cfg.byte_out)
            half <= ~half;
    end
endmodule

// File: rtl/bm_lane_steer.sv
// Module: chooses the data to load into the output register from the head
// word, the half-select bit and the configuration. Purely combinational.
module bm_lane_steer
    import bm_pkg::*;
#(
    parameter int WW = WORD_W,
    localparam int HW = WW / 2
) (
    input  bm_cfg_t       cfg,
    input  logic          half,
    input  logic [WW-1:0] word,
    output logic [WW-1:0] lane
);
    logic pick_low;

    // Lower half is due when the order and the half bit disagree.
    always_comb pick_low = half ^ cfg.little_end;

    // Whole word, or the selected half zero-extended.
    always_comb begin
        if (!cfg.byte_out)
            lane = word;
        else if (pick_low)
            lane = {{(WW-HW){1'b0}}, word[HW-1:0]};
        else
            lane = {{(WW-HW){1'b0}}, word[WW-1:HW]};
    end
endmodule

// File: rtl/bm_word_to_byte.sv
// Module (top): read-side bus matcher. Presents FIFO head words either whole
// or as two ordered halves and strobes word_pop when a word is consumed.
// Assumes head_word stays stable until word_pop.
module bm_word_to_byte
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_endian_le,
    input  logic              strap_byte_out,
    input  logic [WORD_W-1:0] head_word,
    input  logic              head_valid,
    input  logic              rd_en,
    output logic [WORD_W-1:0] q_out,
    output logic              next_half,
    output logic              word_pop
);
    bm_cfg_t           cfg_q;
    logic              take;
    logic [WORD_W-1:0] lane;

    // A request counts only when the FIFO holds a word.
    always_comb take = rd_en && head_valid;

    bm_strap_latch u_straps (
        .clk       (clk),
        .rst_n     (rst_n),
        .endian_in (strap_endian_le),
        .width_in  (strap_byte_out),
        .cfg       (cfg_q)
    );

    bm_half_track u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_q),
        .take      (take),
        .half      (next_half),
        .word_done (word_pop)
    );

    bm_lane_steer #(.WW(WORD_W)) u_steer (
        .cfg  (cfg_q),
        .half (next_half),
        .word (head_word),
        .lane (lane)
    );

    // Output register: load on a taken read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_out <= '0;
        else if (take)
            q_out <= lane;
    end
endmodule

// File: rtl/bm_word_to_byte_chk.sv
// Checker: temporal properties of the bus matcher, bound to the top module.
module bm_word_to_byte_chk
    import bm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              head_valid,
    input logic              rd_en,
    input logic [WORD_W-1:0] q_out,
    input logic              next_half,
    input logic              word_pop,
    input bm_cfg_t           cfg_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q_out == '0 && next_half == 1'b0));

    a_r3_word_pops_each_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.byte_out && rd_en && head_valid) |-> (word_pop && !next_half));

    a_r6_pop_on_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.byte_out && word_pop) |-> next_half);

    a_r6_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.byte_out && rd_en && head_valid) |=> (next_half != $past(next_half)));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(q_out) && $stable(next_half)));

    a_r8_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> !word_pop);

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.byte_out |-> (q_out[WORD_W-1:HALF_W] == '0));
endmodule

bind bm_word_to_byte bm_word_to_byte_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .rd_en      (rd_en),
    .q_out      (q_out),
    .next_half  (next_half),
    .word_pop   (word_pop),
    .cfg_q      (cfg_q)
);

// File: tb/bm_word_to_byte_tb.sv
// Bench: random and directed read traffic in all strap settings, checked
// against a model that latches the configuration only during reset.
module bm_word_to_byte_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_endian_le = 1'b0;
    logic        strap_byte_out = 1'b0;
    logic [17:0] head_word = '0;
    logic        head_valid = 1'b0;
    logic        rd_en = 1'b0;
    logic [17:0] q_out;
    logic        next_half;
    logic        word_pop;

    int checks = 0;
    int fails  = 0;

    logic        m_le, m_byte, m_half;
    logic [17:0] m_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    bm_word_to_byte u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] next_q(input logic [17:0] w);
        if (!m_byte) return w;
        return (m_half ^ m_le) ? {9'b0, w[8:0]} : {9'b0, w[17:9]};
    endfunction

    task automatic do_reset(input logic le, input logic by);
        @(negedge clk);
        rst_n = 1'b0; strap_endian_le = le; strap_byte_out = by; rd_en = 1'b1; head_valid = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 q", q_out, 0);
        chk("R1 half", next_half, 0);
        m_le = le; m_byte = by; m_half = 1'b0; m_q = '0;
        @(negedge clk);
        rst_n = 1'b1; rd_en = 1'b0;
    endtask

    // One cycle of stimulus; straps may be disturbed to test R2.
    task automatic step(input logic rd, input logic vld, input logic [17:0] w, input logic jiggle);
        logic exp_pop;
        @(negedge clk);
        rd_en = rd; head_valid = vld; head_word = w;
        if (jiggle) begin strap_endian_le = ~strap_endian_le; strap_byte_out = ~strap_byte_out; end
        #1;
        exp_pop = rd && vld && (!m_byte || m_half);
        chk(!vld ? "R8 pop" : (!rd ? "R7 pop" : (m_byte ? "R6 pop" : "R3 pop")), word_pop, exp_pop);
        if (rd && vld) begin
            m_q = next_q(w);
            if (m_byte) m_half = ~m_half;
        end
        @(posedge clk); #1;
        chk(m_byte ? (m_le ? "R5 q" : "R4 q") : "R3 q", q_out, m_q);
        chk(jiggle ? "R2 half" : "R6 half", next_half, m_half);
        if (m_byte) chk("R9 upper", q_out[17:9], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // Directed: big-endian bytes, idle between halves, empty reads.
        do_reset(1'b0, 1'b1);
        step(1'b1, 1'b1, 18'h2A5C3, 1'b0);   // R4 upper first
        step(1'b0, 1'b1, 18'h2A5C3, 1'b0);   // R7 idle mid-word
        step(1'b1, 1'b0, 18'h2A5C3, 1'b0);   // R8 empty
        step(1'b1, 1'b1, 18'h2A5C3, 1'b0);   // R4 lower second, pop
        // Directed: little-endian, straps disturbed after reset (R2).
        do_reset(1'b1, 1'b1);
        step(1'b1, 1'b1, 18'h3F001, 1'b1);
        step(1'b1, 1'b1, 18'h3F001, 1'b1);
        // Directed: word mode back to back (R3).
        do_reset(1'b0, 1'b0);
        step(1'b1, 1'b1, 18'h12345, 1'b0);
        step(1'b1, 1'b1, 18'h0ABCD, 1'b1);
        // Random traffic in every configuration.
        for (int c = 0; c < 4; c++) begin
            do_reset(c[0], c[1]);
            for (int i = 0; i < 400; i++) begin
                logic [17:0] w;
                w = 18'($urandom);
                step(1'($urandom), ($urandom % 4) != 0, w, ($urandom % 8) == 0);
                // Hold the head word until popped, as a FIFO would.
                if (m_byte && m_half)
                    step(1'b1, 1'b1, w, 1'b0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule